// File: doc/BRIEF.md
# 6502-to-Z80 Bus Signal Translator

This glue block sits between a CPU with a synchronous bus and a backplane that expects Z80-style control strobes. The CPU has one combined read/write line (high means read) and a phase-2 clock that marks the data half of each bus cycle. The backplane wants separate active-low read and write strobes, separate I/O-request and memory-request strobes, and an M1 line. The block is purely combinational. Every output follows its inputs within the same cycle.

The CPU has no separate I/O space. The block therefore takes a 256-byte page of the CPU map, C000h to C0FFh, and turns accesses to it into I/O requests. Every other address is a memory request. The low address byte passes through unchanged, so a backplane peripheral at port P is reached at CPU address C000h + P.

A strap input can invert address bit 15 on its way to the backplane. This swaps the two halves of the map, so backplane RAM at 8000h–FFFFh appears to the CPU at 0000h–7FFFh. The I/O window is decoded from the CPU-side address, so it stays at C000h–C0FFh whatever the strap setting.

Top module: `bus_xlate`

## Requirements
- R1: `bus_rd_n` is 0 exactly when `cpu_rw` is 1 and `cpu_phi2` is 1; otherwise it is 1.
- R2: `bus_wr_n` is 0 exactly when `cpu_rw` is 0 and `cpu_phi2` is 1; otherwise it is 1.
- R3: While `cpu_phi2` is 0, both `bus_rd_n` and `bus_wr_n` are 1, so `cpu_rw` has no effect on them. At no time are both 0.
- R4: `bus_iorq_n` is 0 exactly when `cpu_addr[15:8]` equals 8'hC0, and 1 otherwise.
- R5: `bus_mreq_n` is always the complement of `bus_iorq_n`.
- R6: `bus_m1_n` is 1 under every input combination.
- R7: `bus_addr[14:0]` equals `cpu_addr[14:0]`. In particular, `bus_addr[7:0]` carries the port number inside the I/O window.
- R8: With `a15_flip` at 0, `bus_addr[15]` equals `cpu_addr[15]`. With `a15_flip` at 1, it equals the inverse of `cpu_addr[15]`.
- R9: `a15_flip` has no effect on `bus_iorq_n` or `bus_mreq_n`. The window is decoded from the CPU address before any inversion.
- R10: The window edges are exact. C000h and C0FFh are I/O, while BFFFh and C100h are memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | Address from the CPU |
| cpu_rw | input | 1 | CPU direction line, 1 = read, 0 = write |
| cpu_phi2 | input | 1 | CPU phase-2 clock, high during the data half of a cycle |
| a15_flip | input | 1 | Strap, 1 = invert address bit 15 toward the backplane |
| bus_addr | output | 16 | Address driven onto the backplane |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_iorq_n | output | 1 | Active-low I/O request |
| bus_mreq_n | output | 1 | Active-low memory request |
| bus_m1_n | output | 1 | M1 line, held inactive |

## Verification
The I/O window decode and the bit-15 flip act in the same cycle on the same address. A design that decoded the flipped address would move the window to 40xxh when the strap is set. The vector table therefore applies in-window addresses such as C000h, C0C0h and C0FFh, and their mirror 40C0h, under both strap values. The bench judges `bus_iorq_n` against the unflipped page while checking `bus_addr[15]` for inversion. The read/write strobes are also driven in the same cycles with both phase-2 levels, so a strobe gated by the wrong phase shows up on window and non-window accesses alike.

// File: rtl/bus_xlate_pkg.sv
// Package: shared defaults and the strobe pair type for the bus translator.
// Assumes a 16-bit CPU address and a 256-byte I/O page unless overridden.
package bus_xlate_pkg;

    localparam int unsigned ADDR_W_DEF  = 16;
    localparam int unsigned WIN_BITS_DEF = 8;
    localparam int unsigned IO_PAGE_DEF = 'hC0;

    // Active-low read/write strobe pair toward the backplane.
    typedef struct packed {
        logic rd_n;
        logic wr_n;
    } strobe_t;

endpackage

// File: rtl/bus_xlate_strobe.sv
// Module: derives separate active-low read and write strobes from the CPU's
// combined direction line, gated by the phase-2 clock.
// Assumes cpu_rw is stable while phi2 is high, as on a synchronous bus.
module bus_xlate_strobe
    import bus_xlate_pkg::*;
(
    input  logic    cpu_rw,
    input  logic    cpu_phi2,
    output strobe_t strobe
);

    // Strobe gating: only the data phase may pull a strobe low.
    always_comb begin
        strobe.rd_n = ~(cpu_rw & cpu_phi2);
        strobe.wr_n = ~(~cpu_rw & cpu_phi2);
    end

endmodule

// File: rtl/bus_xlate_iodec.sv
// Module: decodes one aligned page of the CPU address space as the I/O
// window and produces complementary I/O and memory request strobes.
// Assumes the address given is the CPU-side one, before any remapping.
module bus_xlate_iodec #(
    parameter int unsigned ADDR_W   = bus_xlate_pkg::ADDR_W_DEF,
    parameter int unsigned WIN_BITS = bus_xlate_pkg::WIN_BITS_DEF,
    parameter int unsigned IO_PAGE  = bus_xlate_pkg::IO_PAGE_DEF
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              iorq_n,
    output logic              mreq_n
);

    localparam int unsigned TAG_W = ADDR_W - WIN_BITS;
    localparam logic [TAG_W-1:0] PAGE_TAG = TAG_W'(IO_PAGE);

    logic win_hit;

    // Page compare: the upper address field selects the I/O window.
    always_comb begin
        win_hit = (cpu_addr[ADDR_W-1:WIN_BITS] == PAGE_TAG);
    end

    // Request strobes: outside the window every access is memory.
    always_comb begin
        iorq_n = ~win_hit;
        mreq_n = win_hit;
    end

endmodule

// File: rtl/bus_xlate_addr.sv
// Module: forwards the CPU address to the backplane, optionally inverting
// the top bit to swap the upper and lower halves of the map.
// Assumes the strap is static during operation.
module bus_xlate_addr #(
    parameter int unsigned ADDR_W = bus_xlate_pkg::ADDR_W_DEF
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              a15_flip,
    output logic [ADDR_W-1:0] bus_addr
);

    localparam int unsigned TOP = ADDR_W - 1;

    // Lower bits: straight pass-through, one wire per bit.
    for (genvar i = 0; i < TOP; i++) begin : g_pass
        assign bus_addr[i] = cpu_addr[i];
    end

    // Top bit: inverted when the strap is set.
    assign bus_addr[TOP] = cpu_addr[TOP] ^ a15_flip;

endmodule

// File: rtl/bus_xlate.sv
// Module: top of the bus translator. It turns a synchronous-bus CPU's
// address, direction and phase-2 signals into Z80-style backplane strobes.
// Assumes no wait states and no interrupt acknowledge cycles, so M1 is tied off.
module bus_xlate #(
    parameter int unsigned ADDR_W   = bus_xlate_pkg::ADDR_W_DEF,
    parameter int unsigned WIN_BITS = bus_xlate_pkg::WIN_BITS_DEF,
    parameter int unsigned IO_PAGE  = bus_xlate_pkg::IO_PAGE_DEF
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_phi2,
    input  logic              a15_flip,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_iorq_n,
    output logic              bus_mreq_n,
    output logic              bus_m1_n
);

    import bus_xlate_pkg::*;

    strobe_t strb;

    bus_xlate_strobe u_strobe (
        .cpu_rw   (cpu_rw),
        .cpu_phi2 (cpu_phi2),
        .strobe   (strb)
    );

    bus_xlate_iodec #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .IO_PAGE  (IO_PAGE)
    ) u_iodec (
        .cpu_addr (cpu_addr),
        .iorq_n   (bus_iorq_n),
        .mreq_n   (bus_mreq_n)
    );

    bus_xlate_addr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .cpu_addr (cpu_addr),
        .a15_flip (a15_flip),
        .bus_addr (bus_addr)
    );

    // Output unpacking: strobe pair onto the backplane pins.
    always_comb begin
        bus_rd_n = strb.rd_n;
        bus_wr_n = strb.wr_n;
    end

    // M1 tie-off: no acknowledge cycle ever exists.
    assign bus_m1_n = 1'b1;

endmodule

// File: rtl/bus_xlate_chk.sv
// Module: assertion checker for bus_xlate, bound to every instance.
// Assumes combinational behaviour and checks input/output relations whenever
// all inputs are known.
module bus_xlate_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              cpu_phi2,
    input logic              a15_flip,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_iorq_n,
    input logic              bus_mreq_n,
    input logic              bus_m1_n
);

    logic known;

    // Known-input guard: skip checks before the bench drives the inputs.
    always_comb known = !$isunknown({cpu_addr, cpu_rw, cpu_phi2, a15_flip});

    // Relation checks between the ports.
    always_comb begin
        if (known) begin
            // R1
            rd_dir_chk: assert (bus_rd_n || cpu_rw);
            // R2
            wr_dir_chk: assert (bus_wr_n || !cpu_rw);
            // R3
            idle_phase_chk: assert (cpu_phi2 || (bus_rd_n && bus_wr_n));
            // R3
            one_strobe_chk: assert (bus_rd_n || bus_wr_n);
            // R5
            req_compl_chk: assert (bus_mreq_n != bus_iorq_n);
            // R6
            m1_idle_chk: assert (bus_m1_n == 1'b1);
            // R7
            low_addr_chk: assert (bus_addr[ADDR_W-2:0] == cpu_addr[ADDR_W-2:0]);
            // R8
            top_bit_chk: assert (bus_addr[ADDR_W-1] == (cpu_addr[ADDR_W-1] ^ a15_flip));
            // R9
            win_side_chk: assert (bus_iorq_n || (cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b11));
        end
    end

endmodule

bind bus_xlate bus_xlate_chk #(.ADDR_W(ADDR_W)) chk_i (
    .cpu_addr   (cpu_addr),
    .cpu_rw     (cpu_rw),
    .cpu_phi2   (cpu_phi2),
    .a15_flip   (a15_flip),
    .bus_addr   (bus_addr),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_iorq_n (bus_iorq_n),
    .bus_mreq_n (bus_mreq_n),
    .bus_m1_n   (bus_m1_n)
);

// File: tb/bus_xlate_tb_top.sv
// Bench: walks a table of addresses with known window membership under every
// combination of direction, phase and strap. Directed cases follow.
module bus_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr;
    logic        cpu_rw, cpu_phi2, a15_flip;
    logic [15:0] bus_addr;
    logic        bus_rd_n, bus_wr_n, bus_iorq_n, bus_mreq_n, bus_m1_n;

    int applied = 0;
    int errs    = 0;

    // 50 MHz clock paces stimulus and sampling.
    always #10 clk = ~clk;

    bus_xlate dut_i (
        .cpu_addr   (cpu_addr),
        .cpu_rw     (cpu_rw),
        .cpu_phi2   (cpu_phi2),
        .a15_flip   (a15_flip),
        .bus_addr   (bus_addr),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_iorq_n (bus_iorq_n),
        .bus_mreq_n (bus_mreq_n),
        .bus_m1_n   (bus_m1_n)
    );

    // Vector table: {address, expected window hit per R4/R10}.
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {16'h0000, 1'b0}, {16'h7FFF, 1'b0}, {16'h8000, 1'b0}, {16'hBFFF, 1'b0},
        {16'hC000, 1'b1}, {16'hC001, 1'b1}, {16'hC07F, 1'b1}, {16'hC0C0, 1'b1},
        {16'hC0FF, 1'b1}, {16'hC100, 1'b0}, {16'h40C0, 1'b0}, {16'h00C0, 1'b0},
        {16'hFFFC, 1'b0}, {16'hFFFF, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        applied++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic rw, input logic ph, input logic fl);
        @(posedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_phi2 = ph; a15_flip = fl;
        @(negedge clk);
    endtask

    // Compare every output against the model derived from the requirements.
    task automatic check_all(input logic hit);
        check("R1 rd_n", {15'd0, bus_rd_n}, {15'd0, !(cpu_rw && cpu_phi2)});
        check("R2 wr_n", {15'd0, bus_wr_n}, {15'd0, !(!cpu_rw && cpu_phi2)});
        check("R4 iorq_n", {15'd0, bus_iorq_n}, {15'd0, !hit});
        check("R5 mreq_n", {15'd0, bus_mreq_n}, {15'd0, hit});
        check("R6 m1_n", {15'd0, bus_m1_n}, 16'd1);
        check("R7 R8 addr", bus_addr, {cpu_addr[15] ^ a15_flip, cpu_addr[14:0]});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
        $finish;
    end

    initial begin
        cpu_addr = 16'h0000; cpu_rw = 1'b1; cpu_phi2 = 1'b0; a15_flip = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: phase low, so no strobe (R3), memory space, M1 idle.
        check("R3 reset rd_n", {15'd0, bus_rd_n}, 16'd1);
        check("R3 reset wr_n", {15'd0, bus_wr_n}, 16'd1);
        check("R6 reset m1_n", {15'd0, bus_m1_n}, 16'd1);

        // Table walk over all direction/phase/strap combinations (R1-related sweep).
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < 8; c++) begin
                drive(VEC[v][16:1], c[0], c[1], c[2]);
                check_all(VEC[v][0]);
            end
        end

        // R3: direction toggling while phase is low leaves both strobes idle.
        drive(16'h1234, 1'b0, 1'b0, 1'b0);
        check("R3 rw0 phi2 low", {14'd0, bus_rd_n, bus_wr_n}, 16'd3);
        drive(16'h1234, 1'b1, 1'b0, 1'b0);
        check("R3 rw1 phi2 low", {14'd0, bus_rd_n, bus_wr_n}, 16'd3);

        // R9: strap flips leave the I/O decision at C0xx, not 40xx.
        drive(16'hC055, 1'b0, 1'b1, 1'b1);
        check("R9 C055 flip iorq_n", {15'd0, bus_iorq_n}, 16'd0);
        check("R9 C055 flip addr", bus_addr, 16'h4055);
        check("R2 C055 write", {15'd0, bus_wr_n}, 16'd0);
        drive(16'h4055, 1'b1, 1'b1, 1'b1);
        check("R9 4055 flip iorq_n", {15'd0, bus_iorq_n}, 16'd1);
        check("R1 4055 read", {15'd0, bus_rd_n}, 16'd0);

        // R10: window edges with the strap clear.
        drive(16'hBFFF, 1'b1, 1'b1, 1'b0);
        check("R10 BFFF mreq_n", {15'd0, bus_mreq_n}, 16'd0);
        drive(16'hC100, 1'b1, 1'b1, 1'b0);
        check("R10 C100 mreq_n", {15'd0, bus_mreq_n}, 16'd0);
        drive(16'hC0FF, 1'b1, 1'b1, 1'b0);
        check("R10 C0FF iorq_n", {15'd0, bus_iorq_n}, 16'd0);

        // R7: port number reaches the backplane low byte.
        drive(16'hC0A5, 1'b0, 1'b1, 1'b0);
        check("R7 port byte", {8'd0, bus_addr[7:0]}, 16'h00A5);

        $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
        $finish;
    end

endmodule